// File: doc/BRIEF.md
# Three-Level Prioritized Interrupt Controller

The block gathers one-cycle event pulses from a parameterized set of peripheral sources (24 by default) and holds each one in a sticky pending bit until the CPU services it or software clears it. Each source is given a two-bit code, built from a bit in a high-enable register and a bit in a low-enable register. The code either disables the source or assigns it to one of three priority levels. A global enable flag gates the whole controller. The CPU raises this flag and drops it through dedicated command inputs, and software can also set or clear it through the control register.

On the CPU side, a registered request line and a 5-bit source index form a request/acknowledge handshake. An acknowledge clears the pending bit of the presented source and drops the global enable flag, so the CPU must re-enable interrupts explicitly. Software writes to the pending register only clear bits. A bit is cleared where the written value is 0, and a pulse that arrives in the same cycle always survives. This gives a lossless way to clear selected requests.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A one-cycle high on `src_pulse[i]` sets pending bit i at that clock edge. The bit stays set until it is cleared, and it reads back on `rd_data` with `rd_sel`=0.
- R2: Each source's code is {high-enable bit i (register select 1), low-enable bit i (register select 2)}. Code 00 disables the source, 01 gives level 1, 10 gives level 2 and 11 gives level 3. A pending source with code 00 never wins arbitration.
- R3: A pending enabled source at a higher level always beats one at a lower level, whatever their indices.
- R4: Among pending enabled sources at the same level, the lowest index wins.
- R5: `irq_req` is a register. It rises one cycle after the global enable is set while at least one enabled source is pending, and it is never high otherwise.
- R6: While `irq_req` is high and no acknowledge, register write or disable event occurs, `irq_idx` stays unchanged, even when a source of higher priority becomes pending.
- R7: `irq_ack` high while `irq_req` is high clears the pending bit of `irq_idx` and the global enable at that edge, and `irq_req` is low in the next cycle.
- R8: A write with `wr_sel`=0 clears each pending bit whose `wr_data` bit is 0 and leaves bits written as 1 unchanged. A pulse on the same bit in the same cycle leaves the bit set.
- R9: The global enable is set by `ei_cmd` or by a write with `wr_sel`=3 and `wr_data[0]`=1, and it reads back on `rd_data[0]` with `rd_sel`=3.
- R10: The global enable is cleared by `di_cmd`, `trap_cmd`, `fault_trap`, or a write with `wr_sel`=3 and `wr_data[0]`=0. A clear wins over a set in the same cycle, and a held request drops one cycle after the clear.
- R11: Reset clears every pending bit, every enable bit, the global enable and `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_pulse | input | NUM_SRC | One-cycle event pulses from the sources |
| ei_cmd | input | 1 | Enable-interrupt command from the CPU |
| di_cmd | input | 1 | Disable-interrupt command from the CPU |
| trap_cmd | input | 1 | Trap executed by the CPU |
| fault_trap | input | 1 | Illegal-instruction or oscillator-fail trap |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 pending, 1 high-enable, 2 low-enable, 3 control |
| wr_data | input | NUM_SRC | Write data |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_data | output | NUM_SRC | Read data of the selected register |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_idx | output | 5 | Index of the selected source |
| irq_ack | input | 1 | CPU acknowledge of the presented request |

## Verification
The bench sets a low-index, low-level source against higher-index level-3 sources, so a design that arbitrated by index first would present the wrong source. It pulses a level-3 source with a lower index while a request is already held. An index that is not latched would switch away from the source the CPU is about to acknowledge. It also clears a pending bit with a write while a pulse hits the same bit, and writes all ones to the pending register. A design that lets the write win, or that writes the data in plainly, would drop or invent requests. It fires enable and disable in the same cycle, so a controller that lets the set win would be left enabled.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_ENHI = 2'd1,
    SEL_ENLO = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
`timescale 1ns/1ps
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_pend_regs.sv
`timescale 1ns/1ps
module irq_pend_regs #(
  parameter int NUM_SRC = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pulse,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] pend_d;
  logic               upd;

  // new pulses take precedence over any clear in the same cycle
  always_comb begin
    pend_d = (pend_q & ~clr_mask) | pulse;
    upd    = (|pulse) | (|(pend_q & clr_mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter int NUM_SRC = 24,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] en_hi,
  input  logic [NUM_SRC-1:0] en_lo,
  output logic               any_req,
  output logic [IDX_W-1:0]   win_idx
);
  localparam int NUM_LVL = 3;

  logic [NUM_SRC-1:0] lvl_mask [NUM_LVL];
  logic [NUM_SRC-1:0] sel_mask;

  // lvl_mask[k] holds requests at priority level k+1
  always_comb begin
    lvl_mask[0] = pend & ~en_hi &  en_lo;
    lvl_mask[1] = pend &  en_hi & ~en_lo;
    lvl_mask[2] = pend &  en_hi &  en_lo;
  end

  always_comb begin
    sel_mask = '0;
    for (int k = 0; k < NUM_LVL; k++) begin
      if (|lvl_mask[k]) sel_mask = lvl_mask[k];
    end
    any_req = |sel_mask;
  end

  always_comb begin
    win_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (sel_mask[i]) win_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_gie_ctrl.sv
`timescale 1ns/1ps
module irq_gie_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic gie
);
  logic gie_q;
  logic gie_d;
  logic upd;

  always_comb begin
    upd   = set_req | clr_req;
    gie_d = ~clr_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   gie_q <= 1'b0;
    else if (upd) gie_q <= gie_d;
  end

  assign gie = gie_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic               ei_cmd,
  input  logic               di_cmd,
  input  logic               trap_cmd,
  input  logic               fault_trap,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [NUM_SRC-1:0] wr_data,
  input  logic [1:0]         rd_sel,
  output logic [NUM_SRC-1:0] rd_data,
  output logic               irq_req,
  output logic [IDX_W-1:0]   irq_idx,
  input  logic               irq_ack
);
  logic               rst_sync_n;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] en_hi_q;
  logic [NUM_SRC-1:0] en_lo_q;
  logic [NUM_SRC-1:0] en_hi_d;
  logic [NUM_SRC-1:0] en_lo_d;
  logic               en_hi_we;
  logic               en_lo_we;
  logic               gie_q;
  logic               any_req;
  logic [IDX_W-1:0]   win_idx;
  logic               req_q;
  logic               req_d;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   idx_d;
  logic               out_upd;
  logic               ack_fire;
  logic               held_ok;
  logic [NUM_SRC-1:0] ack_mask;
  logic [NUM_SRC-1:0] wr_clr_mask;
  logic [NUM_SRC-1:0] clr_mask;
  logic               ctrl_we;
  logic               gie_set;
  logic               gie_clr;
  reg_sel_e           wsel;
  reg_sel_e           rsel;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // write decode
  always_comb begin
    wsel        = reg_sel_e'(wr_sel);
    en_hi_we    = wr_en && (wsel == SEL_ENHI);
    en_lo_we    = wr_en && (wsel == SEL_ENLO);
    ctrl_we     = wr_en && (wsel == SEL_CTRL);
    en_hi_d     = wr_data;
    en_lo_d     = wr_data;
    wr_clr_mask = (wr_en && (wsel == SEL_PEND)) ? ~wr_data : '0;
    ack_fire    = irq_ack && req_q;
    ack_mask    = ack_fire ? (NUM_SRC'(1) << idx_q) : '0;
    clr_mask    = wr_clr_mask | ack_mask;
  end

  irq_pend_regs #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pulse    (src_pulse),
    .clr_mask (clr_mask),
    .pend     (pend_q)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   en_hi_q <= '0;
    else if (en_hi_we) en_hi_q <= en_hi_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   en_lo_q <= '0;
    else if (en_lo_we) en_lo_q <= en_lo_d;
  end

  // global enable: any clearing event wins over a set
  always_comb begin
    gie_set = ei_cmd | (ctrl_we & wr_data[0]);
    gie_clr = di_cmd | trap_cmd | fault_trap | ack_fire | (ctrl_we & ~wr_data[0]);
  end

  irq_gie_ctrl u_gie (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_req (gie_set),
    .clr_req (gie_clr),
    .gie     (gie_q)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .pend    (pend_q),
    .en_hi   (en_hi_q),
    .en_lo   (en_lo_q),
    .any_req (any_req),
    .win_idx (win_idx)
  );

  // output stage: hold the presented source while it stays valid
  always_comb begin
    held_ok = req_q && gie_q && pend_q[idx_q] && (en_hi_q[idx_q] | en_lo_q[idx_q]);
    req_d   = req_q;
    idx_d   = idx_q;
    if (ack_fire) begin
      req_d = 1'b0;
    end else if (!held_ok) begin
      req_d = gie_q && any_req;
      idx_d = win_idx;
    end
    out_upd = (req_d != req_q) || (idx_d != idx_q);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      req_q <= 1'b0;
      idx_q <= '0;
    end else if (out_upd) begin
      req_q <= req_d;
      idx_q <= idx_d;
    end
  end

  always_comb begin
    rsel = reg_sel_e'(rd_sel);
    case (rsel)
      SEL_PEND: rd_data = pend_q;
      SEL_ENHI: rd_data = en_hi_q;
      SEL_ENLO: rd_data = en_lo_q;
      default:  rd_data = {{(NUM_SRC-1){1'b0}}, gie_q};
    endcase
  end

  assign irq_req = req_q;
  assign irq_idx = idx_q;
endmodule

// File: rtl/irq_prio_chk.sv
`timescale 1ns/1ps
module irq_prio_chk #(
  parameter int NUM_SRC = 24,
  parameter int IDX_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_pulse,
  input logic [NUM_SRC-1:0] pend,
  input logic               gie,
  input logic               irq_req,
  input logic [IDX_W-1:0]   irq_idx,
  input logic               irq_ack,
  input logic               di_cmd,
  input logic               trap_cmd,
  input logic               fault_trap,
  input logic               wr_en
);
  AST_PULSE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_pulse) |=> ((pend & $past(src_pulse)) == $past(src_pulse))); // R1

  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(gie)); // R5

  AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack && gie && !wr_en && !di_cmd && !trap_cmd && !fault_trap)
      |=> (irq_req && $stable(irq_idx))); // R6

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> (!irq_req && !gie)); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && !src_pulse[irq_idx]) |=> !pend[$past(irq_idx)]); // R7

  AST_GIE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (di_cmd || trap_cmd || fault_trap) |=> !gie); // R10

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |-> (pend == '0 && !gie && !irq_req)); // R11
endmodule

bind irq_prio_ctrl irq_prio_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .src_pulse  (src_pulse),
  .pend       (pend_q),
  .gie        (gie_q),
  .irq_req    (irq_req),
  .irq_idx    (irq_idx),
  .irq_ack    (irq_ack),
  .di_cmd     (di_cmd),
  .trap_cmd   (trap_cmd),
  .fault_trap (fault_trap),
  .wr_en      (wr_en)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;
  localparam int W = 5;

  typedef struct {
    logic        req;
    logic [W-1:0] idx;
    logic        chk_rd;
    logic [N-1:0] rd;
    string       tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src_pulse = '0;
  logic         ei_cmd = 1'b0, di_cmd = 1'b0, trap_cmd = 1'b0, fault_trap = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [N-1:0] wr_data = '0;
  logic [1:0]   rd_sel = '0;
  logic [N-1:0] rd_data;
  logic         irq_req;
  logic [W-1:0] irq_idx;
  logic         irq_ack = 1'b0;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(N), .IDX_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .ei_cmd(ei_cmd),
    .di_cmd(di_cmd), .trap_cmd(trap_cmd), .fault_trap(fault_trap),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_req(irq_req), .irq_idx(irq_idx), .irq_ack(irq_ack)
  );

  // monitor: compares one expected item per cycle, after outputs settle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (irq_req !== e.req || (e.req && irq_idx !== e.idx)) begin
          n_bad++;
          $display("FAIL %s: req/idx actual %b/%0d expected %b/%0d", e.tag, irq_req, irq_idx, e.req, e.idx);
        end
        if (e.chk_rd && rd_data !== e.rd) begin
          n_bad++;
          $display("FAIL %s: rd_data actual %h expected %h", e.tag, rd_data, e.rd);
        end
      end
    end
  end

  task automatic chk(input logic req, input int idx, input logic [1:0] sel,
                     input logic crd, input logic [N-1:0] rd, input string tag);
    exp_t e;
    rd_sel   = sel;
    e.req    = req;
    e.idx    = W'(idx);
    e.chk_rd = crd;
    e.rd     = rd;
    e.tag    = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic [N-1:0] m);
    src_pulse = m;
    @(negedge clk);
    src_pulse = '0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [N-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ei();
    ei_cmd = 1'b1; @(negedge clk); ei_cmd = 1'b0;
    idle(1);
  endtask

  task automatic ack();
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  function automatic logic [N-1:0] b(input int i);
    return N'(1) << i;
  endfunction

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(3);
    // R11 reset state
    chk(0, 0, 2'd0, 1, '0, "R11 pend");
    chk(0, 0, 2'd1, 1, '0, "R11 en_hi");
    chk(0, 0, 2'd3, 1, '0, "R11 ctrl");
    // R1 latch with no enable
    pulse(b(5)); idle(1);
    chk(0, 0, 2'd0, 1, b(5), "R1 sticky");
    wr(2'd1, b(5)); wr(2'd2, b(5)); idle(1);
    chk(0, 0, 2'd0, 1, b(5), "R5 gie off");
    ei();
    chk(1, 5, 2'd3, 1, N'(1), "R9 ei sets");
    ack();
    chk(0, 0, 2'd0, 1, '0, "R7 ack clear");
    chk(0, 0, 2'd3, 1, '0, "R7 gie drop");
    // R3/R4 levels: 2->l2, 3->l1, 7,10->l3
    wr(2'd1, b(2) | b(7) | b(10));
    wr(2'd2, b(3) | b(7) | b(10));
    pulse(b(2) | b(3) | b(7) | b(10));
    wr(2'd3, N'(1)); idle(1);
    chk(1, 7, 2'd3, 1, N'(1), "R3 R9 level first");
    // R6 hold while a better source arrives
    wr(2'd1, b(1) | b(2) | b(7) | b(10));
    wr(2'd2, b(1) | b(3) | b(7) | b(10));
    pulse(b(1)); idle(2);
    chk(1, 7, 2'd0, 0, '0, "R6 hold");
    ack();
    chk(0, 0, 2'd0, 1, b(1) | b(2) | b(3) | b(10), "R7 pend");
    ei();  chk(1, 1, 2'd0, 0, '0, "R4 lowest in l3");
    ack(); ei(); chk(1, 10, 2'd0, 0, '0, "R4 next l3");
    ack(); ei(); chk(1, 2, 2'd0, 0, '0, "R3 l2 over l1");
    ack(); ei(); chk(1, 3, 2'd0, 0, '0, "R2 code01 l1");
    ack();
    chk(0, 0, 2'd0, 1, '0, "R7 all served");
    // R4 same level
    wr(2'd1, b(1) | b(2) | b(7) | b(10) | b(12) | b(20));
    pulse(b(12) | b(20));
    ei(); chk(1, 12, 2'd0, 0, '0, "R4 l2 order");
    // R10 clear sources
    di_cmd = 1'b1; @(negedge clk); di_cmd = 1'b0; idle(1);
    chk(0, 0, 2'd3, 1, '0, "R10 di");
    ei(); chk(1, 12, 2'd0, 0, '0, "R9 re-enable");
    trap_cmd = 1'b1; @(negedge clk); trap_cmd = 1'b0; idle(1);
    chk(0, 0, 2'd3, 1, '0, "R10 trap");
    ei();
    fault_trap = 1'b1; @(negedge clk); fault_trap = 1'b0; idle(1);
    chk(0, 0, 2'd3, 1, '0, "R10 fault");
    ei();
    wr(2'd3, '0); idle(1);
    chk(0, 0, 2'd3, 1, '0, "R10 ctrl write 0");
    ei_cmd = 1'b1; di_cmd = 1'b1; @(negedge clk); ei_cmd = 1'b0; di_cmd = 1'b0; idle(1);
    chk(0, 0, 2'd3, 1, '0, "R10 clear wins");
    // R8 write clear racing a pulse
    src_pulse = b(4);
    wr(2'd0, ~(b(12) | b(4)));
    src_pulse = '0;
    chk(0, 0, 2'd0, 1, b(4) | b(20), "R8 clear vs pulse");
    wr(2'd0, '1);
    chk(0, 0, 2'd0, 1, b(4) | b(20), "R8 ones keep");
    // R2 disabled source ignored
    ei(); chk(1, 20, 2'd0, 0, '0, "R2 code00 skipped");
    ack(); ei();
    chk(0, 0, 2'd0, 1, b(4), "R2 R5 only disabled pending");
    idle(3);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule